// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block decides, frame by frame, whether a received Ethernet frame is kept. It watches the receive byte stream, which arrives with start and end markers, and it reads a CRC-valid flag and an external multicast-hash verdict at the end of each frame. From this it counts the frame length and assigns the frame exactly one class: good, bad-CRC, runt or oversized. From the first six bytes it also classifies the destination address as broadcast, multicast, a match with the programmed station address, or another individual address.

A 16-bit receive-control word selects the kinds of address and the frame classes that are accepted. A frame is kept only when its address class and its length/CRC class are both enabled. The decision and the class flags appear as a one-cycle result after the last byte. A buffer-write enable follows the incoming bytes and stops after the largest legal frame size, so an accepted oversized frame is stored truncated.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset the control word is zero, `done`, `accept` and `buf_we` are low, and every frame is rejected until the control word is written.
- R2: The frame length is the number of bytes with `rx_valid` from the `rx_sof` byte through the `rx_eof` byte. Under 64 bytes is runt, over 1518 is oversized, and otherwise the frame is good when `crc_ok` is high in the end byte's cycle and bad-CRC when it is low. Exactly one of `cls_good`, `cls_crcerr`, `cls_runt`, `cls_long` is set with `done`.
- R3: A frame is accepted only if its address class passes and its frame class is enabled: bit 8 good, bit 12 bad-CRC, bit 13 runt, bit 14 oversized.
- R4: With bit 10 set, a destination address equal to `station_addr` passes. The first address byte on the wire is compared with `station_addr[47:40]`, and the others follow in order.
- R5: With bit 11 set, the all-ones destination address passes.
- R6: With bit 9 set, a multicast address passes when `hash_pass` is high in the end byte's cycle. A multicast address has bit 0 of its first byte set and is not all ones.
- R7: With bit 6 set, an address with bit 0 of its first byte clear passes when `hash_pass` is high in the end byte's cycle.
- R8: With bit 7 set, every destination address passes.
- R9: `buf_we` is high for each valid byte among the first 1518 bytes of a frame and low for all later bytes.
- R10: `done` pulses for one cycle in the cycle after the end byte. `accept` and the class flags are zero whenever `done` is low.
- R11: `ctl_we` loads `ctl_wdata` into the control word on the rising clock edge. The new value applies to frames that end after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| station_addr | input | 48 | Programmed station address, first byte in bits 47:40 |
| hash_pass | input | 1 | External multicast-hash verdict, sampled with the end byte |
| rx_valid | input | 1 | Byte present on `rx_data` |
| rx_sof | input | 1 | First byte of frame (with `rx_valid`) |
| rx_eof | input | 1 | Last byte of frame (with `rx_valid`) |
| rx_data | input | 8 | Received byte |
| crc_ok | input | 1 | CRC check result, sampled with the end byte |
| buf_we | output | 1 | Buffer write enable for the current byte |
| done | output | 1 | Decision valid pulse |
| accept | output | 1 | Frame is kept |
| cls_good | output | 1 | Good frame |
| cls_crcerr | output | 1 | Legal length, bad CRC |
| cls_runt | output | 1 | Shorter than 64 bytes |
| cls_long | output | 1 | Longer than 1518 bytes |

## Verification
`buf_we` is combinational on the byte being presented, so the bench reads it a short delay after driving each byte and compares its total per frame with the expected truncated length. The decision and class flags are due in the single cycle after the end byte's clock edge. The driver pushes the expected result before it sends the frame, and a monitor sampling on the falling edge pops one entry for each `done` pulse. A `done` held for a second cycle, or a pulse with no entry queued, therefore counts as a mismatch, and entries still queued at the end show missing decisions.

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int MAX_LEN    = 1518,
  parameter int MIN_LEN    = 64,
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  input  logic [47:0] station_addr,
  input  logic        hash_pass,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        crc_ok,
  output logic        buf_we,
  output logic        done,
  output logic        accept,
  output logic        cls_good,
  output logic        cls_crcerr,
  output logic        cls_runt,
  output logic        cls_long
);
  localparam int CW = $clog2(MAX_LEN + 3);
  localparam logic [CW-1:0] MAXL = CW'(MAX_LEN);
  localparam logic [CW-1:0] MINL = CW'(MIN_LEN);
  localparam logic [CW-1:0] SATL = CW'(MAX_LEN + 1);
  localparam logic [CW-1:0] DAL  = CW'(ADDR_BYTES);

  logic [15:0]   ctl_q;
  logic [CW-1:0] cnt_q, idx, len;
  logic          bc_q, ia_q, mc_q, bc_n, ia_n, mc_n;
  logic [7:0]    sa_byte;
  logic          first, in_da, eof_v;
  logic          is_runt, is_long, is_good, is_bad, mcast;
  logic          addr_ok, cls_ok;

  assign idx   = rx_sof ? '0 : cnt_q;
  assign len   = idx + CW'(1);
  assign first = (idx == '0);
  assign in_da = (idx < DAL);
  assign eof_v = rx_valid & rx_eof;

  always_comb begin
    sa_byte = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (idx == CW'(i)) sa_byte = station_addr[8*(ADDR_BYTES-1-i) +: 8];
  end

  assign bc_n = in_da ? ((first | bc_q) & (rx_data == 8'hFF))    : bc_q;
  assign ia_n = in_da ? ((first | ia_q) & (rx_data == sa_byte))  : ia_q;
  assign mc_n = first ? rx_data[0] : mc_q;

  assign buf_we = rx_valid & (idx < MAXL);

  assign is_runt = len < MINL;
  assign is_long = len > MAXL;
  assign is_good = !is_runt & !is_long & crc_ok;
  assign is_bad  = !is_runt & !is_long & !crc_ok;
  assign mcast   = mc_n & !bc_n;

  assign addr_ok = ctl_q[7]
                 | (ctl_q[10] & ia_n)
                 | (ctl_q[11] & bc_n)
                 | (ctl_q[9]  & mcast & hash_pass)
                 | (ctl_q[6]  & !mc_n & hash_pass);

  assign cls_ok = (ctl_q[8]  & is_good)
                | (ctl_q[12] & is_bad)
                | (ctl_q[13] & is_runt)
                | (ctl_q[14] & is_long);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bc_q  <= 1'b0;
      ia_q  <= 1'b0;
      mc_q  <= 1'b0;
    end else if (rx_valid) begin
      cnt_q <= (idx >= SATL) ? SATL : len;
      bc_q  <= bc_n;
      ia_q  <= ia_n;
      mc_q  <= mc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      accept     <= 1'b0;
      cls_good   <= 1'b0;
      cls_crcerr <= 1'b0;
      cls_runt   <= 1'b0;
      cls_long   <= 1'b0;
    end else begin
      done       <= eof_v;
      accept     <= eof_v & addr_ok & cls_ok;
      cls_good   <= eof_v & is_good;
      cls_crcerr <= eof_v & is_bad;
      cls_runt   <= eof_v & is_runt;
      cls_long   <= eof_v & is_long;
    end
  end
endmodule

module rx_accept_filter_chk #(
  parameter int MAX_LEN = 1518
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_sof,
  input logic        rx_eof,
  input logic        buf_we,
  input logic        done,
  input logic        accept,
  input logic        cls_good,
  input logic        cls_crcerr,
  input logic        cls_runt,
  input logic        cls_long,
  input logic [15:0] ctl_q
);
  logic [15:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_cnt <= '0;
    else if (rx_valid) wr_cnt <= (rx_sof ? 16'd0 : wr_cnt) + {15'd0, buf_we};
  end

  // R9
  buf_we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> rx_valid);

  // R9
  wr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= 16'(MAX_LEN));

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof) |=> done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !accept && !cls_good && !cls_crcerr && !cls_runt && !cls_long);

  // R2
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({cls_good, cls_crcerr, cls_runt, cls_long}) == 1);

  // R3
  class_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept) |-> ((cls_good && $past(ctl_q[8])) || (cls_crcerr && $past(ctl_q[12]))
                       || (cls_runt && $past(ctl_q[13])) || (cls_long && $past(ctl_q[14]))));
endmodule

bind rx_accept_filter rx_accept_filter_chk #(.MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/rx_accept_filter_tb.sv
`timescale 1ns/1ps
module rx_accept_filter_tb;
  logic        clk = 0, rst_n = 0;
  logic        ctl_we = 0;
  logic [15:0] ctl_wdata = '0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic        hash_pass = 0, rx_valid = 0, rx_sof = 0, rx_eof = 0, crc_ok = 0;
  logic [7:0]  rx_data = '0;
  logic        buf_we, done, accept, cls_good, cls_crcerr, cls_runt, cls_long;

  int vectors = 0, miscompares = 0, cycles = 0;
  logic [15:0] cur_ctl = '0;
  logic [4:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rx_accept_filter u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      finish_run();
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected done", 1, 0);
      end else begin
        automatic logic [4:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {27'd0, accept, cls_good, cls_crcerr, cls_runt, cls_long}, {27'd0, e});
      end
    end
  end

  task automatic write_ctl(logic [15:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
    cur_ctl = v;
  endtask

  task automatic send_frame(string tag, int len, logic [47:0] da, bit crc, bit hp);
    bit runt, lng, good, bad, bc, mc, ia, addr, cls;
    int wr = 0;
    runt = len < 64; lng = len > 1518;
    good = !runt && !lng && crc; bad = !runt && !lng && !crc;
    bc = (da == 48'hFFFF_FFFF_FFFF);
    mc = da[40] && !bc;
    ia = (da == station_addr);
    addr = cur_ctl[7] || (cur_ctl[10] && ia) || (cur_ctl[11] && bc)
        || (cur_ctl[9] && mc && hp) || (cur_ctl[6] && !da[40] && hp);
    cls = (cur_ctl[8] && good) || (cur_ctl[12] && bad)
        || (cur_ctl[13] && runt) || (cur_ctl[14] && lng);
    exp_q.push_back({addr && cls, good, bad, runt, lng});
    tag_q.push_back(tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      crc_ok = crc; hash_pass = hp;
      rx_data = (i < 6) ? 8'(da >> (8 * (5 - i))) : 8'(i * 7 + 3);
      #1;
      if (buf_we) wr++;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; crc_ok = 0; hash_pass = 0;
    chk({tag, " R9 bytes written"}, wr, (len < 1518) ? len : 1518);
  endtask

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h01_00_5E_01_02_03;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset accept", accept, 0);
    chk("R1 reset buf_we", buf_we, 0);
    rst_n = 1;
    @(negedge clk);

    send_frame("R1 no enables", 100, BCAST, 1, 1);
    send_frame("R1 station no enables", 100, 48'h02_11_22_33_44_55, 1, 1);

    write_ctl(16'h0900);            // R11 bit 11 + bit 8
    send_frame("R5 broadcast", 100, BCAST, 1, 0);
    send_frame("R5 unicast rejected", 100, OTHER, 1, 0);

    write_ctl(16'h0500);            // bit 10 + bit 8
    send_frame("R4 station 64", 64, 48'h02_11_22_33_44_55, 1, 0);
    send_frame("R4 last byte differs", 64, OTHER, 1, 0);
    send_frame("R4 first byte differs", 64, 48'h03_11_22_33_44_55, 1, 0);
    send_frame("R2 runt class off", 63, 48'h02_11_22_33_44_55, 1, 0);
    send_frame("R2 bad crc class off", 200, 48'h02_11_22_33_44_55, 0, 0);
    send_frame("R2 good 1518", 1518, 48'h02_11_22_33_44_55, 1, 0);
    send_frame("R3 long class off", 1519, 48'h02_11_22_33_44_55, 1, 0);

    write_ctl(16'h2400);            // bit 10 + bit 13
    send_frame("R3 runt on", 63, 48'h02_11_22_33_44_55, 0, 0);
    send_frame("R3 good off", 64, 48'h02_11_22_33_44_55, 1, 0);

    write_ctl(16'h1400);            // bit 10 + bit 12
    send_frame("R3 crc on", 200, 48'h02_11_22_33_44_55, 0, 0);

    write_ctl(16'h4400);            // bit 10 + bit 14
    send_frame("R9 long truncated", 1600, 48'h02_11_22_33_44_55, 1, 0);

    write_ctl(16'h0300);            // bit 9 + bit 8
    send_frame("R6 mcast hash", 80, MCAST, 1, 1);
    send_frame("R6 mcast no hash", 80, MCAST, 1, 0);
    send_frame("R6 broadcast not mcast", 80, BCAST, 1, 1);

    write_ctl(16'h0140);            // bit 6 + bit 8
    send_frame("R7 unicast hash", 80, OTHER, 1, 1);
    send_frame("R7 unicast no hash", 80, OTHER, 1, 0);
    send_frame("R7 mcast rejected", 80, MCAST, 1, 1);

    write_ctl(16'h0180);            // bit 7 + bit 8
    send_frame("R8 promiscuous", 70, OTHER, 1, 0);
    send_frame("R8 promiscuous mcast", 70, MCAST, 1, 0);
    write_ctl(16'h0080);            // bit 7 alone
    send_frame("R3 promiscuous no class", 70, OTHER, 1, 0);

    repeat (5) @(negedge clk);
    chk("R10 all decisions seen", exp_q.size(), 0);
    chk("R10 done idle", done, 0);
    finish_run();
  end
endmodule